// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-on-Less-Than

This block is an N-bit integer arithmetic and logic unit assembled from identical one-bit slices, one per result bit. Each slice conditions its two operand bits through optional inverters. It then offers the AND, the OR and the full-adder sum of the conditioned bits, plus a "less" input, and a shared two-bit selector picks one of the four. The carries ripple from slice to slice. A 4-bit control word sets the two inverters and the selector, which gives AND, OR, NOR, add, subtract and set-on-less-than.

Subtraction inverts the second operand and injects a carry of one into bit 0. For set-on-less-than, the same subtraction runs and the adder sum bit of the top slice is routed back into the "less" input of bit 0. Every other "less" input is tied low. The block also drives a zero flag, a carry-out and a signed overflow flag. The overflow flag lets a later pipeline stage raise a trap. An optional output register, enabled by default, adds one cycle of latency and gives a clean reset state.

Top module: `sliced_alu`

## Requirements
- R1: Control 4'b0000 gives res = op_a & op_b and control 4'b0001 gives res = op_a | op_b, bit by bit. The control word is {invert_a at bit 3, negate_b at bit 2, select at bits 1:0}, with select 00 = AND, 01 = OR, 10 = sum, 11 = less.
- R2: Control 4'b1100 inverts both operands and selects AND, giving res = ~(op_a | op_b).
- R3: Control 4'b0010 gives res = (op_a + op_b) mod 2^W, and cout is the carry out of the top bit.
- R4: Control 4'b0110 gives res = (op_a - op_b) mod 2^W, computed as op_a + ~op_b + 1. cout is the carry out of that sum, which is 1 exactly when op_a >= op_b unsigned.
- R5: For add, subtract and set-on-less-than, ovf is the carry into the top slice XOR the carry out of it. For add, this means ovf is 1 only when both operands share a sign and the result sign differs. For subtract, it means ovf is 1 only when the operand signs differ and the result sign differs from op_a.
- R6: Control 4'b0111 gives res[0] = bit W-1 of the raw difference op_a - op_b, and res[W-1:1] = 0. cout and ovf are those of the subtraction. When that subtraction overflows, res[0] therefore does not equal the true signed comparison.
- R7: zero is 1 exactly when every bit of res is 0, for every operation.
- R8: When select bit 1 is 0 (AND, OR, NOR), cout and ovf are 0.
- R9: With REG_OUT = 1, every output is valid one clock edge after the inputs. An asynchronous active-low reset forces res = 0, zero = 1, cout = 0 and ovf = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| ctrl | input | 4 | {invert_a, negate_b, select[1:0]} |
| res | output | W | Result |
| zero | output | 1 | High when res is all zeros |
| cout | output | 1 | Carry out of the top slice (arithmetic only) |
| ovf | output | 1 | Signed overflow (arithmetic only) |

## Verification
The zero flag and the overflow flag can be raised by the same operation. Adding the most negative value to itself wraps to zero, so zero, cout and ovf must all be 1 at once. A set-on-less-than whose internal subtraction overflows must show ovf = 1 together with a res[0] taken from the wrapped sign. The bench builds these cases by sweeping every operation over the corner operands 0, -1, the most negative and the most positive value. It compares all four outputs of each case with a reference model that derives overflow from operand and result signs rather than from carries.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int CTRL_W   = 4;
    localparam int CTRL_AINV = 3;
    localparam int CTRL_BNEG = 2;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    localparam logic [CTRL_W-1:0] OPC_AND = 4'b0000;
    localparam logic [CTRL_W-1:0] OPC_OR  = 4'b0001;
    localparam logic [CTRL_W-1:0] OPC_ADD = 4'b0010;
    localparam logic [CTRL_W-1:0] OPC_SUB = 4'b0110;
    localparam logic [CTRL_W-1:0] OPC_SLT = 4'b0111;
    localparam logic [CTRL_W-1:0] OPC_NOR = 4'b1100;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
#(
    parameter bit EXPORT_SET = 1'b0
) (
    input  logic a_i,
    input  logic b_i,
    input  logic a_inv_i,
    input  logic b_inv_i,
    input  logic carry_i,
    input  logic less_i,
    input  sel_e sel_i,
    output logic res_o,
    output logic carry_o,
    output logic set_o
);

    logic a_c;
    logic b_c;
    logic sum;

    // Conditioned operand bits
    always_comb begin
        a_c = a_i ^ a_inv_i;
        b_c = b_i ^ b_inv_i;
    end

    // Full adder
    always_comb begin
        sum     = a_c ^ b_c ^ carry_i;
        carry_o = (a_c & b_c) | (a_c & carry_i) | (b_c & carry_i);
    end

    // Four-way result multiplexer
    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = a_c & b_c;
            SEL_OR:   res_o = a_c | b_c;
            SEL_SUM:  res_o = sum;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

    // Only the top slice exports its sum as the comparison outcome
    generate
        if (EXPORT_SET) begin : g_set
            assign set_o = sum;
        end else begin : g_noset
            assign set_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/alu_zero_tree.sv
module alu_zero_tree #(
    parameter int W     = 32,
    parameter int GROUP = 4
) (
    input  logic [W-1:0] vec_i,
    output logic         zero_o
);

    localparam int NGRP = (W + GROUP - 1) / GROUP;
    localparam int PADW = NGRP * GROUP;

    logic [PADW-1:0] padded;
    logic [NGRP-1:0] grp_any;

    always_comb begin
        padded        = '0;
        padded[W-1:0] = vec_i;
    end

    // First level: OR within each group
    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            assign grp_any[g] = |padded[g*GROUP +: GROUP];
        end
    endgenerate

    // Second level: NOR across groups
    assign zero_o = ~|grp_any;

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
    import alu_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [W-1:0]      res,
    output logic              zero,
    output logic              cout,
    output logic              ovf
);

    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         zero;
        logic         cout;
        logic         ovf;
    } alu_out_t;

    localparam alu_out_t OUT_RST = '{res: '0, zero: 1'b1, cout: 1'b0, ovf: 1'b0};

    logic         a_inv;
    logic         b_neg;
    sel_e         sel;
    logic [W:0]   carry;
    logic [W-1:0] slice_res;
    logic [W-1:0] set_bus;
    logic         set_w;
    logic         zero_w;
    alu_out_t     out_d;
    alu_out_t     out_q;

    always_comb begin
        a_inv = ctrl[CTRL_AINV];
        b_neg = ctrl[CTRL_BNEG];
        sel   = sel_e'(ctrl[1:0]);
    end

    // Negation of b: invert each bit and inject a carry of one
    assign carry[0] = b_neg;

    // Only the top slice drives a nonzero set bit, so the OR is that bit
    assign set_w = |set_bus;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_slice
            logic less_in;
            if (i == 0) begin : g_lsb
                assign less_in = set_w;
            end else begin : g_rest
                assign less_in = 1'b0;
            end

            alu_bit_slice #(
                .EXPORT_SET (i == MSB)
            ) u_slice (
                .a_i     (op_a[i]),
                .b_i     (op_b[i]),
                .a_inv_i (a_inv),
                .b_inv_i (b_neg),
                .carry_i (carry[i]),
                .less_i  (less_in),
                .sel_i   (sel),
                .res_o   (slice_res[i]),
                .carry_o (carry[i+1]),
                .set_o   (set_bus[i])
            );
        end
    endgenerate

    alu_zero_tree #(
        .W     (W),
        .GROUP (4)
    ) u_zero (
        .vec_i  (slice_res),
        .zero_o (zero_w)
    );

    // Next-value process
    always_comb begin
        out_d      = OUT_RST;
        out_d.res  = slice_res;
        out_d.zero = zero_w;
        if (sel == SEL_SUM || sel == SEL_LESS) begin
            out_d.cout = carry[W];
            out_d.ovf  = carry[MSB] ^ carry[W];
        end
    end

    // Register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RST;
        end else begin
            out_q <= out_d;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            assign res  = out_q.res;
            assign zero = out_q.zero;
            assign cout = out_q.cout;
            assign ovf  = out_q.ovf;
        end else begin : g_comb
            assign res  = out_d.res;
            assign zero = out_d.zero;
            assign cout = out_d.cout;
            assign ovf  = out_d.ovf;
        end
    endgenerate

endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk
    import alu_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      op_a,
    input logic [W-1:0]      op_b,
    input logic [CTRL_W-1:0] ctrl,
    input logic [W-1:0]      res,
    input logic              zero,
    input logic              cout,
    input logic              ovf
);

    logic [W-1:0]      a_q, b_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              seen_q;
    logic [W-1:0]      a_v, b_v;
    logic [CTRL_W-1:0] ctrl_v;
    logic              seen_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            ctrl_q <= '0;
            seen_q <= 1'b0;
        end else begin
            a_q    <= op_a;
            b_q    <= op_b;
            ctrl_q <= ctrl;
            seen_q <= 1'b1;
        end
    end

    generate
        if (REG_OUT) begin : g_lat
            assign a_v    = a_q;
            assign b_v    = b_q;
            assign ctrl_v = ctrl_q;
            assign seen_v = seen_q;

            a_r9_reset_state: assert property (@(posedge clk)
                !rst_n |=> (res == '0 && zero && !cout && !ovf));
        end else begin : g_now
            assign a_v    = op_a;
            assign b_v    = op_b;
            assign ctrl_v = ctrl;
            assign seen_v = 1'b1;
        end
    endgenerate

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        seen_v |-> (zero == (res == '0)));

    a_r8_logic_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_v && !ctrl_v[1]) |-> (!cout && !ovf));

    a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_v && ctrl_v == OPC_ADD) |-> (res == W'(a_v + b_v)));

    a_r4_sub_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_v && ctrl_v == OPC_SUB) |-> (res == W'(a_v - b_v)));

    a_r5_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_v && ctrl_v == OPC_ADD) |->
        (ovf == ((a_v[W-1] == b_v[W-1]) && (res[W-1] != a_v[W-1]))));

    a_r5_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_v && ctrl_v == OPC_SUB) |->
        (ovf == ((a_v[W-1] != b_v[W-1]) && (res[W-1] != a_v[W-1]))));

    a_r6_slt_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_v && ctrl_v == OPC_SLT) |-> (res[W-1:1] == '0));

endmodule

bind sliced_alu sliced_alu_chk #(
    .W       (W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .ctrl  (ctrl),
    .res   (res),
    .zero  (zero),
    .cout  (cout),
    .ovf   (ovf)
);

// File: tb/sim_sliced_alu.sv
`timescale 1ns/1ps
module sim_sliced_alu;

    localparam int W  = 32;
    localparam int NV = 12;
    localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] VNEG = '1;

    // {ctrl, a, b, expected res}
    localparam logic [4+3*W-1:0] VEC [NV] = '{
        {4'b0010, 32'd7,        32'd6,        32'd13},
        {4'b0110, 32'd7,        32'd6,        32'd1},
        {4'b0110, 32'd6,        32'd7,        32'hFFFF_FFFF},
        {4'b0000, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h00F0_F000},
        {4'b0001, 32'hF0F0_0000, 32'h0F00_000F, 32'hFFF0_000F},
        {4'b1100, 32'hF0F0_0000, 32'h0F00_000F, 32'h000F_FFF0},
        {4'b0111, 32'd3,        32'd9,        32'd1},
        {4'b0111, 32'd9,        32'd3,        32'd0},
        {4'b0111, 32'hFFFF_FFFE, 32'd1,        32'd1},
        {4'b0010, 32'h7FFF_FFFF, 32'd1,        32'h8000_0000},
        {4'b0010, 32'h8000_0000, 32'h8000_0000, 32'd0},
        {4'b0110, 32'h8000_0000, 32'd1,        32'h7FFF_FFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   ctrl = '0;
    logic [W-1:0] res;
    logic         zero, cout, ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sliced_alu #(.W(W), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .ctrl(ctrl),
        .res(res), .zero(zero), .cout(cout), .ovf(ovf)
    );

    // Reference model: overflow from operand and result signs
    function automatic logic [W+2:0] ref_model(input logic [3:0] c,
                                               input logic [W-1:0] a,
                                               input logic [W-1:0] b);
        logic [W-1:0] aa, bb, r;
        logic [W:0]   s;
        logic         co, ov;
        aa = c[3] ? ~a : a;
        bb = c[2] ? ~b : b;
        s  = {1'b0, aa} + {1'b0, bb} + {{W{1'b0}}, c[2]};
        co = 1'b0;
        ov = 1'b0;
        case (c[1:0])
            2'b00: r = aa & bb;
            2'b01: r = aa | bb;
            2'b10: r = s[W-1:0];
            default: r = {{(W-1){1'b0}}, s[W-1]};
        endcase
        if (c[1]) begin
            co = s[W];
            ov = (aa[W-1] == bb[W-1]) && (s[W-1] != aa[W-1]);
        end
        return {r, (r == '0), co, ov};
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000, 4'b0001: return "R1";
            4'b1100:          return "R2";
            4'b0010:          return "R3";
            4'b0110:          return "R4";
            default:          return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (R9 latency)
    task automatic run_op(input logic [3:0] c, input logic [W-1:0] a,
                          input logic [W-1:0] b);
        logic [W+2:0] e;
        string t;
        @(negedge clk);
        ctrl = c; op_a = a; op_b = b;
        @(negedge clk);
        e = ref_model(c, a, b);
        t = tag_of(c);
        check(t, "res", res, e[W+2:3]);
        check("R7", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, e[2]});
        if (c[1]) begin
            check("R5", "cout", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, e[1]});
            check("R5", "ovf",  {{(W-1){1'b0}}, ovf},  {{(W-1){1'b0}}, e[0]});
        end else begin
            check("R8", "cout", {{(W-1){1'b0}}, cout}, '0);
            check("R8", "ovf",  {{(W-1){1'b0}}, ovf},  '0);
        end
    endtask

    task automatic check_reset_state(input string what);
        check("R9", {what, " res"},  res, '0);
        check("R9", {what, " zero"}, {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
        check("R9", {what, " cout"}, {{(W-1){1'b0}}, cout}, '0);
        check("R9", {what, " ovf"},  {{(W-1){1'b0}}, ovf},  '0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corners [4];
        logic [3:0]   opcodes [6];
        corners = '{'0, VNEG, VMIN, VMAX};
        opcodes = '{4'b0000, 4'b0001, 4'b1100, 4'b0010, 4'b0110, 4'b0111};

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("reset");
        rst_n = 1'b1;

        // Vector table with hand-computed results
        for (int v = 0; v < NV; v++) begin
            logic [3:0]   c;
            logic [W-1:0] a, b, er;
            {c, a, b, er} = VEC[v];
            run_op(c, a, b);
            check(tag_of(c), "table res", res, er);
        end

        // R3 R5 R7: most negative plus itself wraps to zero with both flags
        run_op(4'b0010, VMIN, VMIN);
        check("R7", "min+min zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
        check("R5", "min+min ovf",  {{(W-1){1'b0}}, ovf},  {{(W-1){1'b0}}, 1'b1});
        check("R3", "min+min cout", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, 1'b1});

        // R6: overflowing comparison min < 1 reports the wrapped sign (0)
        run_op(4'b0111, VMIN, 32'd1);
        check("R6", "slt overflow res", res, '0);
        check("R5", "slt overflow ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, 1'b1});

        // R4: 0 - 1 borrows, cout low
        run_op(4'b0110, '0, 32'd1);
        check("R4", "0-1 cout", {{(W-1){1'b0}}, cout}, '0);

        // Corner sweep over all operations
        for (int o = 0; o < 6; o++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    run_op(opcodes[o], corners[i], corners[j]);

        // Random operands
        for (int k = 0; k < 300; k++)
            run_op(opcodes[k % 6], W'($urandom), W'($urandom));

        // R9: output holds until the next clock edge
        run_op(4'b0010, 32'd5, 32'd5);
        @(negedge clk);
        ctrl = 4'b0000; op_a = '0; op_b = '0;
        #1;
        check("R9", "hold before edge", res, 32'd10);
        @(negedge clk);
        check("R9", "after edge", res, '0);

        // R9: reset in mid-run
        run_op(4'b0001, VNEG, '0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule